// File: doc/BRIEF.md
# Stalled Rotor Watchdog with Automatic Retry

This block supervises a two-phase fan motor by watching the already conditioned rotor-position level for changes. While the motor is in its run state and the level keeps toggling, the drive stays enabled. If no toggle arrives for a full detection window, the block withdraws the drive enable. The enable gates the high-side PWM driver and both low-side phase drivers together. The block then sits out a retry window and re-enables the drive so the motor can try to start again. A rotor that stays jammed is cycled through detect, disable and retry for as long as the fault lasts.

Both windows are counted in PWM-period ticks rather than in clock cycles, so they stretch and shrink with the PWM oscillator. At a PWM rate near 22.7 kHz the defaults give about one second of detection and about eight seconds of retry. A status output is presented as a pull-low enable for an external open-drain pad. It pulls the line low while the fan is healthy and releases it while the rotor is declared stalled. In the sleep state the watchdog is held cleared, and it starts a fresh detection window when run is entered.

Top module: `rotor_stall_guard`

## Requirements
- R1: During and straight after reset the block is in the not-stalled condition: `stall_pull_low` is 1 and `drive_en` equals `run_en`.
- R2: In run, when `DETECT_TICKS` cycles with `pwm_tick`=1 pass with no change of `hall_lvl`, the block is stalled from the following cycle on. In that state `drive_en` is 0 and `stall_pull_low` is 0. After `DETECT_TICKS`-1 such ticks it is still not stalled.
- R3: Any change of `hall_lvl`, rising or falling, restarts the detection window from zero.
- R4: Once stalled, the block stays stalled for `RETRY_TICKS` ticks. After the last of them it returns to not-stalled, with `drive_en`=1 and `stall_pull_low`=1, and a fresh detection window begins.
- R5: If the rotor still does not move after a retry, the detect, disable and retry sequence repeats without limit.
- R6: Changes of `hall_lvl` while stalled have no effect on the retry window or on the outputs.
- R7: While `run_en` is 0, `drive_en` is 0, `stall_pull_low` is 1, and both windows are held cleared, even if ticks arrive. On return to run a full detection window is needed before a stall is declared.
- R8: Cycles with `pwm_tick`=0 advance neither window.
- R9: If a `hall_lvl` change and a tick fall in the same cycle, the change wins and the detection window restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_tick | input | 1 | One-cycle pulse per PWM period |
| hall_lvl | input | 1 | Conditioned rotor-position level |
| run_en | input | 1 | 1 = run state, 0 = sleep |
| drive_en | output | 1 | Enable for the high-side and both low-side drivers |
| stall_pull_low | output | 1 | 1 = pull status line low (healthy), 0 = release (stalled) |

## Verification
The rotor level is toggled at regular intervals shorter than the window, which tells a counter that clears on both edge polarities apart from one that clears on only one. It is then frozen for exactly one tick short of the window and then for the full window, which pins the off-by-one in stall detection. Ticks are spaced apart by idle cycles to show that only ticks advance time. A change coinciding with a tick separates edge priority from tick priority. Toggles during the retry window, repeated stalls, and a sleep entered in mid-fault with ticks still arriving show that the fault ignores motion, repeats, and is wiped by sleep.

// File: rtl/rotor_stall_guard.sv
module rotor_stall_guard #(
  parameter int DETECT_TICKS = 22700,
  parameter int RETRY_TICKS  = 181600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_tick,
  input  logic hall_lvl,
  input  logic run_en,
  output logic drive_en,
  output logic stall_pull_low
);

  localparam int DW = $clog2(DETECT_TICKS + 1);
  localparam int RW = $clog2(RETRY_TICKS + 1);
  localparam logic [DW-1:0] DET_LAST = DW'(DETECT_TICKS - 1);
  localparam logic [RW-1:0] RET_LAST = RW'(RETRY_TICKS - 1);

  logic          hall_q;
  logic          stalled;
  logic [DW-1:0] det_cnt;
  logic [RW-1:0] ret_cnt;
  logic          moved;

  assign moved = hall_lvl ^ hall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hall_q <= 1'b0;
    else        hall_q <= hall_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stalled <= 1'b0;
      det_cnt <= '0;
      ret_cnt <= '0;
    end else if (!run_en) begin
      stalled <= 1'b0;
      det_cnt <= '0;
      ret_cnt <= '0;
    end else if (!stalled) begin
      if (moved) begin
        det_cnt <= '0;
      end else if (pwm_tick) begin
        if (det_cnt == DET_LAST) begin
          stalled <= 1'b1;
          det_cnt <= '0;
          ret_cnt <= '0;
        end else begin
          det_cnt <= det_cnt + 1'b1;
        end
      end
    end else if (pwm_tick) begin
      if (ret_cnt == RET_LAST) begin
        stalled <= 1'b0;
        ret_cnt <= '0;
        det_cnt <= '0;
      end else begin
        ret_cnt <= ret_cnt + 1'b1;
      end
    end
  end

  assign drive_en       = run_en & ~stalled;
  assign stall_pull_low = ~stalled;

  AST_DET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    det_cnt <= DET_LAST); // R2

  AST_STALL_ONLY_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stalled) |-> ($past(pwm_tick) && $past(det_cnt) == DET_LAST && !$past(moved))); // R2

  AST_RETRY_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stalled) && $past(run_en)) |-> ($past(pwm_tick) && $past(ret_cnt) == RET_LAST)); // R4

  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !stalled && moved) |=> (det_cnt == '0 && !stalled)); // R3

  AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!stalled && det_cnt == '0 && ret_cnt == '0)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !pwm_tick && !moved) |=> ($stable(det_cnt) && $stable(ret_cnt) && $stable(stalled))); // R8

  AST_STALL_IGNORES_MOTION: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && stalled && !pwm_tick) |=> ($stable(ret_cnt) && stalled)); // R6

endmodule

// File: tb/rotor_stall_guard_test.sv
`timescale 1ns/1ps
module rotor_stall_guard_test;
  localparam int DET = 5;
  localparam int RET = 8;

  logic clk = 0, rst_n = 0, pwm_tick = 0, hall_lvl = 0, run_en = 0;
  logic drive_en, stall_pull_low;
  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";

  rotor_stall_guard #(.DETECT_TICKS(DET), .RETRY_TICKS(RET)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .hall_lvl(hall_lvl),
    .run_en(run_en), .drive_en(drive_en), .stall_pull_low(stall_pull_low));

  always #2.5 clk = ~clk;

  // behavioural reference: ticks since last motion, fault flag
  int  m_quiet = 0, m_wait = 0;
  bit  m_fault = 0, m_last = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_quiet = 0; m_wait = 0; m_fault = 0; m_last = 0;
    end else begin
      bit changed;
      changed = (hall_lvl != m_last);
      m_last  = hall_lvl;
      if (!run_en) begin
        m_fault = 0; m_quiet = 0; m_wait = 0;
      end else if (m_fault) begin
        if (pwm_tick) begin
          m_wait++;
          if (m_wait >= RET) begin m_fault = 0; m_wait = 0; m_quiet = 0; end
        end
      end else if (changed) begin
        m_quiet = 0;
      end else if (pwm_tick) begin
        m_quiet++;
        if (m_quiet >= DET) begin m_fault = 1; m_quiet = 0; m_wait = 0; end
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (drive_en !== (run_en && !m_fault) || stall_pull_low !== !m_fault) begin
      errors++;
      $display("FAIL %s cycle %0d: drive_en=%b stall_pull_low=%b expected %b %b",
               phase, cycles, drive_en, stall_pull_low, run_en && !m_fault, !m_fault);
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cycles);
      finish_run();
    end
  end

  task automatic cyc(input logic h, input logic t);
    hall_lvl = h; pwm_tick = t;
    @(posedge clk); #1;
    pwm_tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(hall_lvl, 1'b1);
  endtask

  task automatic expect_out(input logic de, input logic pl, input string tag);
    @(negedge clk);
    checks++;
    if (drive_en !== de || stall_pull_low !== pl) begin
      errors++;
      $display("FAIL %s: drive_en=%b stall_pull_low=%b expected %b %b",
               tag, drive_en, stall_pull_low, de, pl);
    end
  endtask

  initial begin
    phase = "R1";
    repeat (3) @(posedge clk);
    #1;
    expect_out(1'b0, 1'b1, "R1 in reset");
    rst_n = 1;
    cyc(1'b0, 1'b0);
    expect_out(1'b0, 1'b1, "R1 after reset sleeping");
    run_en = 1;
    cyc(1'b0, 1'b0);
    expect_out(1'b1, 1'b1, "R1 run entered");

    phase = "R3";
    for (int k = 0; k < 6; k++) begin
      ticks(DET - 1);
      cyc(~hall_lvl, 1'b0);
    end
    expect_out(1'b1, 1'b1, "R3 toggling keeps drive");

    phase = "R2";
    ticks(DET - 1);
    expect_out(1'b1, 1'b1, "R2 one tick short");
    ticks(1);
    expect_out(1'b0, 1'b0, "R2 stalled at window");

    phase = "R6";
    for (int k = 0; k < RET - 1; k++) cyc(~hall_lvl, 1'b1);
    cyc(~hall_lvl, 1'b0);
    expect_out(1'b0, 1'b0, "R6 motion ignored in retry");

    phase = "R4";
    ticks(1);
    expect_out(1'b1, 1'b1, "R4 retry expired");

    phase = "R5";
    ticks(DET);
    expect_out(1'b0, 1'b0, "R5 second stall");
    ticks(RET);
    expect_out(1'b1, 1'b1, "R5 second restart");

    phase = "R8";
    repeat (30) cyc(hall_lvl, 1'b0);
    expect_out(1'b1, 1'b1, "R8 idle cycles no stall");
    for (int k = 0; k < DET - 1; k++) begin
      cyc(hall_lvl, 1'b1);
      repeat (3) cyc(hall_lvl, 1'b0);
    end
    expect_out(1'b1, 1'b1, "R8 sparse ticks short");
    ticks(1);
    expect_out(1'b0, 1'b0, "R8 sparse ticks stall");
    ticks(RET);

    phase = "R9";
    ticks(DET - 1);
    cyc(~hall_lvl, 1'b1);
    ticks(DET - 1);
    expect_out(1'b1, 1'b1, "R9 edge beat tick");
    ticks(1);
    expect_out(1'b0, 1'b0, "R9 stall after fresh window");

    phase = "R7";
    run_en = 0;
    ticks(DET + 3);
    expect_out(1'b0, 1'b1, "R7 sleep clears stall");
    run_en = 1;
    ticks(DET - 1);
    expect_out(1'b1, 1'b1, "R7 fresh window after run");
    ticks(1);
    expect_out(1'b0, 1'b0, "R7 stall after full window");

    repeat (3) cyc(hall_lvl, 1'b0);
    finish_run();
  end
endmodule